// File: doc/BRIEF.md
# Dual-Bank Ping-Pong Capture Buffer

This block sits between an acquisition producer and a host reader. Each accepted producer word first goes into a one-stage input latch. It is then written into the active one of two equal on-chip memory banks, at consecutive addresses starting from zero. When the word at the top address of a bank has been written, the block marks that bank as ready for the host. The writer then moves on to the other bank on the very next word, so capture does not pause.

The host reads any bank through a bank select and a word address. Read data appears one clock after the address is presented. The host reads a ready bank while the producer fills the other one. When the host has finished with a bank, it pulses that bank's acknowledge, which frees the bank for writing again. Banks are always filled in strict alternation. If the writer reaches the next bank while the host still holds it, the writer stops, drops every arriving word and raises a sticky overflow flag. It resumes at address zero of that same bank once the host releases it.

The writer is a four-state machine:
- FILL0 and FILL1 write into bank 0 and bank 1.
- WAIT0 and WAIT1 are blocked, waiting for bank 0 or bank 1 to be released.

Transitions:
- FILL0 goes to FILL1 on the last word when bank 1 is free or is acknowledged in that cycle. Otherwise it goes to WAIT1.
- FILL1 goes to FILL0 or WAIT0 in the same way.
- WAIT1 goes to FILL1 once bank 1's ready flag is clear.
- WAIT0 goes to FILL0 once bank 0's ready flag is clear.
- Synchronous reset enters FILL0 with the write address at zero.

Each bank holds `DEPTH` words of `DATA_W` bits. With 32-bit words, a deployment with 1 Mbit per bank sets `DEPTH` to 32768. The default `DEPTH` is kept small.

Top module: `pp_capture_buffer`

## Requirements
- R1: Synchronous reset clears both ready flags (`bank_ready` = 2'b00) and the overflow flag, and points the writer at bank 0, address 0.
- R2: Each cycle with `wr_valid` high stores `wr_data` at the next address of the active bank, starting at address 0, in arrival order.
- R3: After the word at address DEPTH-1 of a bank is written, that bank's ready bit (`bank_ready[0]` for bank 0, `bank_ready[1]` for bank 1) sets two clocks after the word was presented. The next word goes to address 0 of the other bank with no word lost.
- R4: The host can read a ready bank while the producer writes the other bank, and the concurrent writes do not change the data read.
- R5: A one-cycle pulse on `rd_ack[b]` clears `bank_ready[b]`. An acknowledge of a bank that is not ready has no effect.
- R6: While the writer is blocked, with the next bank still ready, arriving words are dropped, `overflow` sets, and both banks keep their contents.
- R7: A blocked writer waits only for the next bank in alternation. Releasing the other bank does not resume writing. Releasing the awaited bank resumes writing at its address 0.
- R8: Cycles with `wr_valid` low write nothing and do not advance the write address.
- R9: `overflow` stays set until reset.
- R10: `rd_data` shows the word at (`rd_bank`, `rd_addr`) as sampled at the previous rising clock edge, with `rd_bank` 0 selecting bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer word valid |
| wr_data | input | DATA_W | Producer packed word |
| rd_bank | input | 1 | Host bank select (0 or 1) |
| rd_addr | input | AW | Host word address |
| rd_data | output | DATA_W | Host read data, one-cycle latency |
| rd_ack | input | 2 | Host release pulse, one bit per bank |
| bank_ready | output | 2 | Bank full and waiting for the host, one bit per bank |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
The hardest situation to reach is the blocked writer: both banks full and the writer waiting on one particular bank. It is also hard to show that freeing the other bank does not let writing restart. The stimulus fills bank 0, then bank 1, and releases only bank 0. It refills bank 0 so that both flags are set, and then pushes extra words that must be dropped. Next it releases bank 0 alone and pushes one more word, which must also vanish. Readback of both banks after each step shows that no stored word was touched.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        ST_FILL0 = 2'd0,
        ST_FILL1 = 2'd1,
        ST_WAIT0 = 2'd2,
        ST_WAIT1 = 2'd3
    } wr_state_e;
    localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/pp_input_latch.sv
module pp_input_latch #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              lat_valid,
    output logic [DATA_W-1:0] lat_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_valid <= 1'b0;
        end else begin
            lat_valid <= in_valid;
        end
        lat_data <= in_data;
    end
endmodule

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pp_write_fsm.sv
module pp_write_fsm
    import pp_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lat_valid,
    input  logic [NUM_BANKS-1:0] ack,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic [AW-1:0]        wr_addr,
    output logic [NUM_BANKS-1:0] ready,
    output logic                 overflow
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    wr_state_e state_q, state_nx;
    logic      at_last;
    logic      drop;

    assign at_last = lat_valid && (wr_addr == LAST_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL0;
        end else begin
            state_q <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FILL0: if (at_last) state_nx = (ready[1] && !ack[1]) ? ST_WAIT1 : ST_FILL1;
            ST_FILL1: if (at_last) state_nx = (ready[0] && !ack[0]) ? ST_WAIT0 : ST_FILL0;
            ST_WAIT0: if (!ready[0]) state_nx = ST_FILL0;
            ST_WAIT1: if (!ready[1]) state_nx = ST_FILL1;
        endcase
    end

    // outputs
    always_comb begin
        bank_we = '0;
        drop    = 1'b0;
        unique case (state_q)
            ST_FILL0: bank_we[0] = lat_valid;
            ST_FILL1: bank_we[1] = lat_valid;
            ST_WAIT0,
            ST_WAIT1: drop = lat_valid;
        endcase
    end

    // write address: wraps to zero after the top word of a bank
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
        end else if (|bank_we) begin
            wr_addr <= (wr_addr == LAST_ADDR) ? '0 : wr_addr + 1'b1;
        end
    end

    // ready flags and sticky overflow
    always_ff @(posedge clk) begin
        if (rst) begin
            ready    <= '0;
            overflow <= 1'b0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                ready[b] <= (ready[b] && !ack[b]) || (bank_we[b] && wr_addr == LAST_ADDR);
            end
            overflow <= overflow || drop;
        end
    end

    assert_ready_rises_from_fill_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready[0]) |-> $past(state_q) == ST_FILL0);

    assert_switch_starts_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL0 && state_nx == ST_FILL1) |=> wr_addr == '0);

    assert_no_write_when_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT0 || state_q == ST_WAIT1) |-> bank_we == '0);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_idle_holds_addr_R8: assert property (@(posedge clk) disable iff (rst)
        !lat_valid |=> $stable(wr_addr));

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_ack_chk
            assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
                (ready[g] && ack[g]) |=> !ready[g]);
        end
    endgenerate
endmodule

// File: rtl/pp_capture_buffer.sv
module pp_capture_buffer
    import pp_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        rd_ack,
    output logic [1:0]        bank_ready,
    output logic              overflow
);
    logic                 lat_valid;
    logic [DATA_W-1:0]    lat_data;
    logic [NUM_BANKS-1:0] bank_we;
    logic [AW-1:0]        wr_addr;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];
    logic                 rd_sel_q;

    pp_input_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (wr_valid),
        .in_data   (wr_data),
        .lat_valid (lat_valid),
        .lat_data  (lat_data)
    );

    pp_write_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lat_valid (lat_valid),
        .ack       (rd_ack),
        .bank_we   (bank_we),
        .wr_addr   (wr_addr),
        .ready     (bank_ready),
        .overflow  (overflow)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_bank
            pp_bank_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
                .clk   (clk),
                .we    (bank_we[g]),
                .waddr (wr_addr),
                .wdata (lat_data),
                .raddr (rd_addr),
                .rdata (bank_rdata[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        rd_sel_q <= rd_bank;
    end

    assign rd_data = bank_rdata[rd_sel_q];

    assert_single_bank_write_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_we));
endmodule

// File: tb/test_pp_capture_buffer.sv
`timescale 1ns/1ps
module test_pp_capture_buffer;
    localparam int DEPTH = 8;
    localparam int DW    = 32;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_bank = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [1:0]    rd_ack = 2'b00;
    logic [1:0]    bank_ready;
    logic          overflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    pp_capture_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) i_pp_capture_buffer (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_ack(rd_ack), .bank_ready(bank_ready), .overflow(overflow)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor: one read result per cycle, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), rd_data, exp_q.pop_front(), "read data");
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic produce(logic [DW-1:0] base, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = base + DW'(i);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic host_read(bit b, int a, logic [DW-1:0] e, string tag);
        @(negedge clk);
        rd_bank = b;
        rd_addr = AW'(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic read_bank(bit b, logic [DW-1:0] base, string tag);
        for (int a = 0; a < DEPTH; a++) host_read(b, a, base + DW'(a), tag);
    endtask

    task automatic release_bank(int b);
        @(negedge clk);
        rd_ack[b] = 1'b1;
        @(negedge clk);
        rd_ack = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1", {30'd0, bank_ready}, 32'd0, "ready after reset");
        check("R1", {31'd0, overflow}, 32'd0, "overflow after reset");

        // R8: gap in valid does not advance address
        produce(32'hA000_0000, 3);
        idle(3);
        check("R8", {30'd0, bank_ready}, 32'd0, "ready mid-fill");
        produce(32'hA000_0003, 5);
        idle(2);
        check("R3", {30'd0, bank_ready}, 32'd1, "bank0 ready after fill");

        // R4, R10: read bank0 while writing bank1
        fork
            produce(32'hB000_0000, 4);
            read_bank(1'b0, 32'hA000_0000, "R4");
        join
        idle(2);

        // R5: ack of a non-ready bank
        release_bank(1);
        idle(1);
        check("R5", {30'd0, bank_ready}, 32'd1, "ack non-ready bank");
        release_bank(0);
        idle(1);
        check("R5", {30'd0, bank_ready}, 32'd0, "ack clears bank0");

        produce(32'hB000_0004, 4);
        idle(2);
        check("R3", {30'd0, bank_ready}, 32'd2, "bank1 ready after fill");
        read_bank(1'b1, 32'hB000_0000, "R3");

        // fill bank0 again -> both ready, writer blocked on bank1
        produce(32'hC000_0000, 8);
        idle(2);
        check("R6", {30'd0, bank_ready}, 32'd3, "both ready");
        produce(32'hD000_0000, 2);
        idle(2);
        check("R6", {31'd0, overflow}, 32'd1, "overflow on drop");
        read_bank(1'b0, 32'hC000_0000, "R6");
        read_bank(1'b1, 32'hB000_0000, "R6");

        // R7: freeing bank0 does not resume writing
        release_bank(0);
        idle(1);
        check("R7", {30'd0, bank_ready}, 32'd2, "only bank1 ready");
        produce(32'hEEEE_0000, 1);
        idle(2);
        check("R7", {30'd0, bank_ready}, 32'd2, "still blocked");
        host_read(1'b0, 0, 32'hC000_0000, "R7");
        host_read(1'b1, 0, 32'hB000_0000, "R7");
        release_bank(1);
        idle(2);
        produce(32'hE000_0001, 8);
        idle(2);
        check("R7", {30'd0, bank_ready}, 32'd2, "bank1 refilled");
        read_bank(1'b1, 32'hE000_0001, "R7");
        check("R9", {31'd0, overflow}, 32'd1, "overflow sticky");

        // R1: reset again
        do_reset();
        check("R1", {30'd0, bank_ready}, 32'd0, "ready after second reset");
        check("R1", {31'd0, overflow}, 32'd0, "overflow after second reset");
        produce(32'hF000_0000, 1);
        idle(2);
        host_read(1'b0, 0, 32'hF000_0000, "R1");
        idle(3);
        check("R2", {30'd0, bank_ready}, 32'd0, "single word no ready");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule